// File: doc/BRIEF.md
# SPI Register Port with Time Snapshot

This block is the serial slave that lets a host reach a small timekeeping register file and a 256-byte scratch memory. The host lowers chip select and sends an address byte. Bit 7 of that byte selects the direction, and bits 6:0 give the starting register. Every later byte in the same chip-select-low period reads or writes the register under an auto-incrementing pointer. The read window (00h–13h) and the write window (80h–93h) each wrap back to their own start.

The seven time and date bytes are counted outside this block and arrive on `live_time`. Reads of those bytes come from a shadow copy. The shadow is loaded when chip select falls and again whenever a burst pointer wraps to 00h. A multibyte read therefore returns one coherent moment while the live counters keep running. A write to a time byte leaves the block as a one-cycle strobe on the `tw_*` pins. Writes to the alarm, control and offset bytes are held here and appear on `cfg_flat`. The SRAM is reached through an address register at 18h and a data port at 19h.

The serial bus runs far slower than `clk`, so SCLK, MOSI and chip select are synchronised and edge-detected. The serial interface cannot be stalled. For that reason the time-write strobe carries no ready: the counter logic must take every pulse in the cycle it appears.

Top module: `spis_rtc_port`

## Requirements
- R1: The first byte after chip select falls is an address byte. Bit 7 = 1 selects a write burst and bit 7 = 0 a read burst, and bits 6:0 are the start register. Read data is driven only in read bursts; `spi_miso_oe` stays 0 for every byte of a write burst.
- R2: After each data byte the pointer advances. In either direction, register 13h is followed by register 00h, so a read burst wraps 13h→00h and a write burst wraps 93h→80h.
- R3: Registers 14h–17h and 1Ah–7Fh are reserved. A read of a reserved register keeps `spi_miso_oe` at 0. A write to one changes no register and raises no strobe. In both cases the pointer does not advance.
- R4: When chip select falls, and when the pointer wraps to 00h, the block copies `live_time` into the shadow. Reads of 00h–06h return shadow bytes, where register k is `live_time[8k+7:8k]`.
- R5: A write is committed once the 8th bit of its data byte has been sampled, before the next byte begins. A write to register k (0–6) gives one `tw_valid` pulse with `tw_index`=k and the masked data. A write to 07h–10h or 13h updates that register, which reads back and appears at `cfg_flat[8(a-7)+7:8(a-7)]`.
- R6: Bits defined as zero read 0 and ignore writes. The masks are 00h/01h/02h 7Fh, 03h 07h, 04h 3Fh, 05h 9Fh and 13h 01h. All other bytes in 00h–10h use FFh. Registers 11h and 12h are read-only and return `temp_word[15:8]` and `temp_word[7:0]`.
- R7: Register 18h holds the SRAM address and 19h is the data port. A burst at 18h moves on to 19h. Each access at 19h increments the SRAM address, wrapping from FFh to 00h, and leaves the pointer at 19h.
- R8: Bytes travel MSB first. MOSI is sampled on the rising edge of SCLK and MISO changes on the falling edge. `spi_miso_oe` is 0 whenever chip select is high.
- R9: After reset, `spi_miso_oe`, `tw_valid` and all of `cfg_flat` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (pad tri-state when 0) |
| live_time | input | 56 | Running time and date bytes, register k in bits 8k+7:8k |
| temp_word | input | 16 | Read-only value returned at 11h (high) and 12h (low) |
| tw_valid | output | 1 | One-cycle strobe for a time-byte write |
| tw_index | output | 3 | Time register written (0–6) |
| tw_data | output | 8 | Masked byte written |
| cfg_flat | output | 104 | Registers 07h–13h, 07h in the low byte |

## Verification
The assertions assume that each SCLK level lasts several system clocks, so no two serial edges fall within the synchroniser delay. They also assume that chip select changes only while SCLK is idle high, and that `live_time` is stable during the cycles in which a snapshot is taken. The bench holds each SCLK level for ten clocks and leaves six clocks of guard time around every chip-select edge. It changes `live_time` only between bytes, well away from the capture points. All checks are made at the serial pins and the strobe outputs, with expected values taken from the masks and address rules stated above.

// File: rtl/spis_pkg.sv
package spis_pkg;
  localparam int unsigned ADDR_W    = 7;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned TIME_N    = 7;
  localparam logic [6:0]  CFG_FIRST = 7'h07;
  localparam logic [6:0]  LAST_REG  = 7'h13;
  localparam logic [6:0]  TEMP_HI   = 7'h11;
  localparam logic [6:0]  TEMP_LO   = 7'h12;
  localparam logic [6:0]  SADDR_REG = 7'h18;
  localparam logic [6:0]  SDATA_REG = 7'h19;
  localparam int unsigned CFG_N     = int'(LAST_REG) - int'(CFG_FIRST) + 1;

  // bits that may hold a one; everything else reads zero
  function automatic logic [7:0] wmask(input logic [6:0] a);
    case (a)
      7'h00, 7'h01, 7'h02: wmask = 8'h7F;
      7'h03:               wmask = 8'h07;
      7'h04:               wmask = 8'h3F;
      7'h05:               wmask = 8'h9F;
      7'h11, 7'h12:        wmask = 8'h00;
      7'h13:               wmask = 8'h01;
      default:             wmask = 8'hFF;
    endcase
  endfunction

  function automatic logic is_rsvd(input logic [6:0] a);
    is_rsvd = (a > LAST_REG && a < SADDR_REG) || (a > SDATA_REG);
  endfunction
endpackage

// File: rtl/spis_phy.sv
module spis_phy #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       mosi,
  input  logic       tx_load,
  input  logic [7:0] tx_byte,
  input  logic       tx_oe,
  output logic       miso,
  output logic       miso_oe,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       first_byte,
  output logic       cs_fall
);
  logic [SYNC_STAGES-1:0] cs_pipe, sclk_pipe, mosi_pipe;
  logic cs_s, sclk_s, mosi_s, cs_q, sclk_q;
  logic rise, fall, first;
  logic [2:0] bitcnt;
  logic [7:0] sh, tx_sh;
  logic oe;

  assign cs_s   = cs_pipe[SYNC_STAGES-1];
  assign sclk_s = sclk_pipe[SYNC_STAGES-1];
  assign mosi_s = mosi_pipe[SYNC_STAGES-1];
  assign rise   = ~cs_s & sclk_s & ~sclk_q;
  assign fall   = ~cs_s & ~sclk_s & sclk_q;
  assign cs_fall = ~cs_s & cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_pipe    <= '1;
      sclk_pipe  <= '1;
      mosi_pipe  <= '0;
      cs_q       <= 1'b1;
      sclk_q     <= 1'b1;
      bitcnt     <= '0;
      first      <= 1'b1;
      sh         <= '0;
      byte_done  <= 1'b0;
      rx_byte    <= '0;
      first_byte <= 1'b0;
    end else begin
      cs_pipe   <= {cs_pipe[SYNC_STAGES-2:0], cs_n};
      sclk_pipe <= {sclk_pipe[SYNC_STAGES-2:0], sclk};
      mosi_pipe <= {mosi_pipe[SYNC_STAGES-2:0], mosi};
      cs_q      <= cs_s;
      sclk_q    <= sclk_s;
      byte_done <= 1'b0;
      if (cs_s) begin
        bitcnt <= '0;
        first  <= 1'b1;
        sh     <= '0;
      end else if (rise) begin
        sh     <= {sh[6:0], mosi_s};
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          byte_done  <= 1'b1;
          rx_byte    <= {sh[6:0], mosi_s};
          first_byte <= first;
          first      <= 1'b0;
        end
      end
    end
  end

  // transmit side: load after a byte, shift on falling edges inside a byte
  always_ff @(posedge clk) begin
    if (!rst_n || cs_s) begin
      tx_sh <= '0;
      oe    <= 1'b0;
    end else if (tx_load) begin
      tx_sh <= tx_byte;
      oe    <= tx_oe;
    end else if (fall && bitcnt != 3'd0) begin
      tx_sh <= {tx_sh[6:0], 1'b0};
    end
  end

  assign miso    = tx_sh[7];
  assign miso_oe = oe & ~cs_n;

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !oe);
  p_byte_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> (bitcnt == 3'd0) && !first);
endmodule

// File: rtl/spis_regs.sv
module spis_regs
  import spis_pkg::*;
#(
  parameter int unsigned SRAM_AW = 8,
  parameter int unsigned TW_IW   = $clog2(TIME_N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     byte_done,
  input  logic [7:0]               rx_byte,
  input  logic                     first_byte,
  input  logic                     cs_fall,
  input  logic [TIME_N*BYTE_W-1:0] live_time,
  input  logic [15:0]              temp_word,
  output logic                     tx_load,
  output logic [7:0]               tx_byte,
  output logic                     tx_oe,
  output logic                     tw_valid,
  output logic [TW_IW-1:0]         tw_index,
  output logic [7:0]               tw_data,
  output logic [CFG_N*BYTE_W-1:0]  cfg_flat
);
  localparam int unsigned SRAM_D = 1 << SRAM_AW;

  logic                     wr_mode;
  logic [ADDR_W-1:0]        ptr, nptr;
  logic [SRAM_AW-1:0]       saddr, nsaddr;
  logic [TIME_N*BYTE_W-1:0] shadow;
  logic [7:0]               cfg [CFG_N];
  logic [7:0]               mem [SRAM_D];
  logic                     snap_wrap, do_wr;
  logic [7:0]               rd;

  // pointer and SRAM address successor
  always_comb begin
    nptr      = ptr;
    nsaddr    = saddr;
    snap_wrap = 1'b0;
    do_wr     = 1'b0;
    if (first_byte) begin
      nptr = rx_byte[ADDR_W-1:0];
    end else begin
      do_wr = wr_mode && !is_rsvd(ptr);
      if (is_rsvd(ptr)) begin
        nptr = ptr;
      end else if (ptr == SDATA_REG) begin
        nsaddr = saddr + 1'b1;
      end else if (ptr == LAST_REG) begin
        nptr      = '0;
        snap_wrap = 1'b1;
      end else begin
        nptr = ptr + 1'b1;
      end
      if (do_wr && ptr == SADDR_REG) nsaddr = rx_byte[SRAM_AW-1:0];
    end
  end

  // read data for the register the next byte will touch
  always_comb begin
    rd = '0;
    for (int g = 0; g < TIME_N; g++)
      if (nptr == ADDR_W'(g))
        rd = (snap_wrap ? live_time[g*BYTE_W +: BYTE_W] : shadow[g*BYTE_W +: BYTE_W])
             & wmask(ADDR_W'(g));
    for (int g = 0; g < CFG_N; g++)
      if (nptr == CFG_FIRST + ADDR_W'(g)) rd = cfg[g];
    if (nptr == TEMP_HI)   rd = temp_word[15:8];
    if (nptr == TEMP_LO)   rd = temp_word[7:0];
    if (nptr == SADDR_REG) rd = 8'(saddr);
    if (nptr == SDATA_REG) rd = mem[nsaddr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_mode  <= 1'b0;
      ptr      <= '0;
      saddr    <= '0;
      tx_load  <= 1'b0;
      tx_byte  <= '0;
      tx_oe    <= 1'b0;
      tw_valid <= 1'b0;
      tw_index <= '0;
      tw_data  <= '0;
    end else begin
      tx_load  <= byte_done;
      tw_valid <= 1'b0;
      if (byte_done) begin
        if (first_byte) wr_mode <= rx_byte[7];
        ptr     <= nptr;
        saddr   <= nsaddr;
        tx_byte <= rd;
        tx_oe   <= (first_byte ? ~rx_byte[7] : ~wr_mode) && !is_rsvd(nptr);
        if (do_wr && ptr < ADDR_W'(TIME_N)) begin
          tw_valid <= 1'b1;
          tw_index <= ptr[TW_IW-1:0];
          tw_data  <= rx_byte & wmask(ptr);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                  shadow <= '0;
    else if (cs_fall || (byte_done && snap_wrap)) shadow <= live_time;
  end

  always_ff @(posedge clk)
    if (byte_done && do_wr && ptr == SDATA_REG) mem[saddr] <= rx_byte;

  for (genvar g = 0; g < CFG_N; g++) begin : g_cfg
    localparam logic [ADDR_W-1:0] A = CFG_FIRST + ADDR_W'(g);
    always_ff @(posedge clk) begin
      if (!rst_n)                           cfg[g] <= '0;
      else if (byte_done && do_wr && ptr == A) cfg[g] <= rx_byte & wmask(A);
    end
    assign cfg_flat[g*BYTE_W +: BYTE_W] = cfg[g];
  end

  p_rsvd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !first_byte && is_rsvd(ptr) |=> ptr == $past(ptr));
  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !first_byte && ptr == LAST_REG |=> ptr == '0);
  p_snap_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> shadow == $past(live_time));
  p_tw_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tw_valid |-> tw_index < TW_IW'(TIME_N));
  p_write_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load && wr_mode |-> !tx_oe);
  p_sram_stay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !first_byte && ptr == SDATA_REG |=> ptr == SDATA_REG);
  always_comb
    p_zero_bits_r6: assert ((cfg[CFG_N-1] & 8'hFE) == 8'h00);
endmodule

// File: rtl/spis_rtc_port.sv
module spis_rtc_port
  import spis_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SRAM_AW     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     spi_cs_n,
  input  logic                     spi_sclk,
  input  logic                     spi_mosi,
  output logic                     spi_miso,
  output logic                     spi_miso_oe,
  input  logic [TIME_N*BYTE_W-1:0] live_time,
  input  logic [15:0]              temp_word,
  output logic                     tw_valid,
  output logic [2:0]               tw_index,
  output logic [7:0]               tw_data,
  output logic [CFG_N*BYTE_W-1:0]  cfg_flat
);
  logic       byte_done, first_byte, cs_fall, tx_load, tx_oe;
  logic [7:0] rx_byte, tx_byte;

  spis_phy #(.SYNC_STAGES(SYNC_STAGES)) u_phy (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
    .tx_load(tx_load), .tx_byte(tx_byte), .tx_oe(tx_oe),
    .miso(spi_miso), .miso_oe(spi_miso_oe), .byte_done(byte_done),
    .rx_byte(rx_byte), .first_byte(first_byte), .cs_fall(cs_fall)
  );

  spis_regs #(.SRAM_AW(SRAM_AW), .TW_IW(3)) u_regs (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .rx_byte(rx_byte),
    .first_byte(first_byte), .cs_fall(cs_fall), .live_time(live_time),
    .temp_word(temp_word), .tx_load(tx_load), .tx_byte(tx_byte), .tx_oe(tx_oe),
    .tw_valid(tw_valid), .tw_index(tw_index), .tw_data(tw_data), .cfg_flat(cfg_flat)
  );
endmodule

// File: tb/sim_spis_rtc_port.sv
module sim_spis_rtc_port;
  localparam int H = 10;
  localparam int NV = 7;
  // {write address, write data, read address, expected, requirement number}
  localparam logic [39:0] VEC [NV] = '{
    {8'h87, 8'hFF, 8'h07, 8'hFF, 8'd5},  // R5 alarm byte full width
    {8'h8E, 8'h5A, 8'h0E, 8'h5A, 8'd5},  // R5 control byte
    {8'h93, 8'hFF, 8'h13, 8'h01, 8'd6},  // R6 single-bit register
    {8'h91, 8'hAA, 8'h11, 8'hC3, 8'd6},  // R6 read-only high
    {8'h92, 8'h55, 8'h12, 8'h3C, 8'd6},  // R6 read-only low
    {8'h90, 8'h81, 8'h10, 8'h81, 8'd5},  // R5 offset byte
    {8'h8D, 8'h3E, 8'h0D, 8'h3E, 8'd5}   // R5 second alarm byte
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1, mosi = 1'b0;
  logic spi_miso, spi_miso_oe, tw_valid;
  logic [55:0] live_time = '0;
  logic [15:0] temp_word = 16'hC33C;
  logic [2:0] tw_index;
  logic [7:0] tw_data;
  logic [103:0] cfg_flat;
  logic [7:0] tw_seen [8];
  int tw_cnt = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spis_rtc_port u0 (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .live_time(live_time),
    .temp_word(temp_word), .tw_valid(tw_valid), .tw_index(tw_index),
    .tw_data(tw_data), .cfg_flat(cfg_flat)
  );

  always @(negedge clk) if (tw_valid) begin
    tw_seen[tw_index] <= tw_data;
    tw_cnt <= tw_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cs_on;
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic cs_off;
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output bit oe);
    rx = '0;
    oe = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0;
      mosi = tx[i];
      repeat (H) @(negedge clk);
      rx[i] = spi_miso;
      oe &= spi_miso_oe;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected 0 hung cycles", 200000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    bit oe;
    int c0;
    logic [103:0] cf0;
    logic [55:0] ta, tb, tc;
    ta = {8'h24, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h58};
    tb = {8'h24, 8'h12, 8'h31, 8'h05, 8'h23, 8'h08, 8'hD9};
    tc = {8'h24, 8'h12, 8'h31, 8'h05, 8'h23, 8'h08, 8'h33};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    chk(spi_miso_oe == 1'b0, "R9", "miso_oe after reset", 64'(spi_miso_oe), 64'h0);
    chk(tw_valid == 1'b0, "R9", "tw_valid after reset", 64'(tw_valid), 64'h0);
    chk(cfg_flat == '0, "R9", "cfg_flat after reset", cfg_flat[63:0], 64'h0);

    // table: one-byte write then one-byte read per row (R5 or R6)
    for (int v = 0; v < NV; v++) begin
      cs_on; xfer(VEC[v][39:32], r, oe); xfer(VEC[v][31:24], r, oe);
      chk(!oe, "R1", "write data byte drove miso", 64'(oe), 64'h0);
      cs_off;
      cs_on; xfer(VEC[v][23:16], r, oe); xfer(8'h00, r, oe); cs_off;
      chk(r == VEC[v][15:8] && oe, $sformatf("R%0d", VEC[v][7:0]),
          $sformatf("table row %0d read", v), 64'({oe, r}), 64'({1'b1, VEC[v][15:8]}));
    end
    chk(cfg_flat[7:0] == 8'hFF, "R5", "cfg_flat 07h byte", 64'(cfg_flat[7:0]), 64'hFF);
    chk(spi_miso_oe == 1'b0, "R8", "miso_oe with cs high", 64'(spi_miso_oe), 64'h0);

    // R5 R6 time write burst, strobe per byte with masking
    c0 = tw_cnt;
    cs_on; xfer(8'h80, r, oe);
    xfer(8'hFF, r, oe);
    chk(tw_cnt == c0 + 1, "R5", "strobe after first byte", 64'(tw_cnt - c0), 64'h1);
    xfer(8'h12, r, oe); xfer(8'hFF, r, oe); xfer(8'hFF, r, oe);
    xfer(8'hFF, r, oe); xfer(8'hFF, r, oe); xfer(8'h99, r, oe);
    cs_off;
    chk(tw_cnt == c0 + 7, "R5", "strobe count", 64'(tw_cnt - c0), 64'h7);
    chk({tw_seen[6], tw_seen[5], tw_seen[4], tw_seen[3], tw_seen[2], tw_seen[1], tw_seen[0]}
        == 56'h999F3F077F127F, "R6", "masked time writes",
        64'({tw_seen[6], tw_seen[5], tw_seen[4], tw_seen[3], tw_seen[2], tw_seen[1], tw_seen[0]}),
        64'h00999F3F077F127F);

    // R2 write wrap 93h -> 80h
    c0 = tw_cnt;
    cs_on; xfer(8'h92, r, oe); xfer(8'h11, r, oe); xfer(8'h00, r, oe); xfer(8'h45, r, oe);
    cs_off;
    chk(tw_cnt == c0 + 1 && tw_seen[0] == 8'h45, "R2", "write wrap to seconds",
        64'({tw_cnt[7:0] - c0[7:0], tw_seen[0]}), 64'h0145);
    chk(cfg_flat[103:96] == 8'h00, "R2", "13h written before wrap", 64'(cfg_flat[103:96]), 64'h0);

    // R4 snapshot at cs fall, R2 read wrap with fresh snapshot
    live_time = ta;
    cs_on;
    live_time = tb;
    xfer(8'h00, r, oe);
    for (int i = 0; i < 20; i++) begin
      xfer(8'h00, r, oe);
      if (i < 7)
        chk(r == ta[i*8 +: 8], "R4", $sformatf("shadow byte %0d", i), 64'(r), 64'(ta[i*8 +: 8]));
      if (i == 7)
        chk(r == 8'hFF, "R2", "burst reaches 07h", 64'(r), 64'hFF);
    end
    xfer(8'h00, r, oe);
    chk(r == 8'h59, "R4", "wrap snapshot seconds masked", 64'(r), 64'h59);
    xfer(8'h00, r, oe);
    chk(r == 8'h08, "R2", "wrap then minutes", 64'(r), 64'h08);
    cs_off;
    live_time = tc;
    cs_on; xfer(8'h00, r, oe); xfer(8'h00, r, oe); cs_off;
    chk(r == 8'h33, "R4", "new snapshot on cs fall", 64'(r), 64'h33);

    // R3 reserved read and write
    cs_on; xfer(8'h15, r, oe); xfer(8'h00, r, oe);
    chk(!oe, "R3", "reserved read drives miso", 64'(oe), 64'h0);
    xfer(8'h00, r, oe);
    chk(!oe, "R3", "pointer held on reserved", 64'(oe), 64'h0);
    cs_off;
    cs_on; xfer(8'h1A, r, oe); xfer(8'h00, r, oe); cs_off;
    chk(!oe, "R3", "reserved 1Ah read", 64'(oe), 64'h0);
    c0 = tw_cnt;
    cf0 = cfg_flat;
    cs_on; xfer(8'h95, r, oe); xfer(8'hFF, r, oe); xfer(8'hFF, r, oe); cs_off;
    chk(tw_cnt == c0 && cfg_flat == cf0, "R3", "reserved write side effect",
        64'(tw_cnt - c0), 64'h0);

    // R7 SRAM port with address wrap
    cs_on; xfer(8'h98, r, oe); xfer(8'hFE, r, oe); xfer(8'hAA, r, oe);
    xfer(8'hBB, r, oe); xfer(8'hCC, r, oe); cs_off;
    cs_on; xfer(8'h18, r, oe); xfer(8'h00, r, oe); cs_off;
    chk(r == 8'h01, "R7", "address after three data writes", 64'(r), 64'h01);
    cs_on; xfer(8'h98, r, oe); xfer(8'hFF, r, oe); cs_off;
    cs_on; xfer(8'h18, r, oe);
    xfer(8'h00, r, oe);
    chk(r == 8'hFF, "R7", "address register read", 64'(r), 64'hFF);
    xfer(8'h00, r, oe);
    chk(r == 8'hBB, "R7", "data at FFh", 64'(r), 64'hBB);
    xfer(8'h00, r, oe);
    chk(r == 8'hCC, "R7", "data after wrap to 00h", 64'(r), 64'hCC);
    cs_off;
    chk(spi_miso_oe == 1'b0, "R8", "miso_oe released", 64'(spi_miso_oe), 64'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule